// File: doc/BRIEF.md
# Two-wire configuration register slave

This block is a serial slave on a two-wire bus (I2C style). An external bus master uses it to read and write a bank of eight 8-bit configuration registers. The block samples the clock and data lines with the local system clock. It recognises START, repeated START and STOP conditions. It answers to one 7-bit device address, in which a single bit is chosen by an input pin. The first byte of a write sets an internal register pointer.

The master can write one register, or it can write a burst that advances the pointer after each byte and wraps within the eight-register window. To read, the master sets the pointer, issues a repeated START and sends the read address. The block then returns the selected register, MSB first. The data line is only ever pulled low; the pad and its pull-up are outside the block. Register contents are presented in parallel on a flat output vector, with register i at bits [8i+7:8i].

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset all eight registers read 0x00 and the SDA drive enable is low (line released).
- R2: The device address is 1,0,1,1,S,0,0 from A6 down to A0, where S is the level of `addr_sel`. This gives 0x58 when `addr_sel`=0 and 0x5C when `addr_sel`=1. The slave pulls SDA low in the ninth clock of an address byte that matches; the R/W bit is the LSB of that byte, with 0 for write and 1 for read.
- R3: When the address does not match, the slave leaves SDA released through the ACK clock and for every later byte, and changes no register, until the next START or STOP.
- R4: In a write, the first byte after the address is ACKed and loaded into the pointer. Only its low 3 bits are used, so 0x0E selects register 6.
- R5: A data byte is written into the register at the pointer, and becomes visible on `regs_o`, during that byte's ACK and before any STOP.
- R6: After each data byte the pointer increments modulo 8. A burst of nine bytes that starts at register 6 fills registers 6,7,0,…,5 and then overwrites register 6. Each byte is ACKed.
- R7: A read begins with a pointer write, then a repeated START and the address with R/W=1. The slave ACKs the address and then shifts out the pointed register MSB first. After a master NACK it stops driving.
- R8: The SDA drive enable changes only while SCL is low, except that it is released at once on START or STOP.
- R9: A STOP or repeated START that arrives partway through a data byte discards the bits already received. No register changes and the pointer keeps its value.
- R10: In a read, a master ACK after a byte advances the pointer modulo 8 and the slave sends the next register. A NACK ends the read without advancing the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (as seen on the wire) |
| addr_sel | input | 1 | Sets address bit A2; tie low for the default address |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| regs_o | output | 64 | Register contents, register i in bits [8i+7:8i] |

## Verification
The main function is tried with several bus patterns. A single write followed by a random read shows whether the pointer and the data path agree. A pointer byte with high bits set shows whether the pointer is truncated. A nine-byte burst from register 6 separates correct wrap-around from a saturating or a non-advancing pointer. Register checks made after each ACK and before STOP separate commit-at-ACK from commit-at-STOP. Traffic to the wrong address, sent under both `addr_sel` levels, shows address decode and the ignore state. Bytes cut short by STOP or by a repeated START, and a sequential read with master ACK followed by NACK, show whether partial bits leak into the registers and whether a read advances the pointer.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter int NREG = 8,
  parameter logic [3:0] DEV_HI = 4'b1011,
  parameter logic [1:0] DEV_LO = 2'b00
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel,
  output logic                 sda_oe,
  output logic [NREG*8-1:0]    regs_o
);
  localparam int DW = 8;
  localparam int PW = $clog2(NREG);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDAT, S_WACK, S_RDAT, S_RACK, S_SKIP
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_r, sda_r, scl_d, sda_d;
  logic       start_c, stop_c, scl_rise, scl_fall;
  st_t        st;
  logic [3:0] cnt;
  logic [DW-1:0] sh, tx;
  logic [PW-1:0] ptr, ptr_nx;
  logic       rw, mack;
  logic [DW-1:0] regs [NREG];

  assign scl_r    = scl_sy[1];
  assign sda_r    = sda_sy[1];
  assign start_c  = scl_r & scl_d & sda_d & ~sda_r;
  assign stop_c   = scl_r & scl_d & ~sda_d & sda_r;
  assign scl_rise = scl_r & ~scl_d;
  assign scl_fall = ~scl_r & scl_d;
  assign ptr_nx   = ptr + 1'b1;

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DW +: DW] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_r;
      sda_d  <= sda_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sda_oe <= 1'b0;
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (start_c) begin
      st     <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (scl_rise) begin
      case (st)
        S_ADDR, S_PTR, S_WDAT: begin
          sh  <= {sh[DW-2:0], sda_r};
          cnt <= cnt + 1'b1;
        end
        S_RDAT: cnt <= cnt + 1'b1;
        S_RACK: mack <= ~sda_r;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (st)
        S_ADDR: if (cnt == 4'd8) begin
          if (sh[7:1] == {DEV_HI, addr_sel, DEV_LO}) begin
            st     <= S_AACK;
            rw     <= sh[0];
            sda_oe <= 1'b1;
          end else begin
            st <= S_SKIP;
          end
        end
        S_AACK: begin
          cnt <= '0;
          if (rw) begin
            st     <= S_RDAT;
            tx     <= regs[ptr];
            sda_oe <= ~regs[ptr][DW-1];
          end else begin
            st     <= S_PTR;
            sda_oe <= 1'b0;
          end
        end
        S_PTR: if (cnt == 4'd8) begin
          ptr    <= sh[PW-1:0];
          st     <= S_PACK;
          sda_oe <= 1'b1;
        end
        S_WDAT: if (cnt == 4'd8) begin
          regs[ptr] <= sh;
          ptr       <= ptr_nx;
          st        <= S_WACK;
          sda_oe    <= 1'b1;
        end
        S_PACK, S_WACK: begin
          st     <= S_WDAT;
          cnt    <= '0;
          sda_oe <= 1'b0;
        end
        S_RDAT: begin
          if (cnt == 4'd8) begin
            st     <= S_RACK;
            sda_oe <= 1'b0;
          end else begin
            tx     <= {tx[DW-2:0], 1'b0};
            sda_oe <= ~tx[DW-2];
          end
        end
        S_RACK: begin
          if (mack) begin
            ptr    <= ptr_nx;
            tx     <= regs[ptr_nx];
            sda_oe <= ~regs[ptr_nx][DW-1];
            cnt    <= '0;
            st     <= S_RDAT;
          end else begin
            st <= S_SKIP;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_cfg_slave_chk.sv
module i2c_cfg_slave_chk #(
  parameter int W  = 64,
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_c,
  input logic          stop_c,
  input logic          sda_oe,
  input logic [W-1:0]  regs_o,
  input logic [PW-1:0] ptr
);
  a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!scl_s || !sda_oe));

  a_r5_commit_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> sda_oe);

  a_r6_ptr_steps_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> ptr == PW'($past(ptr) + 1'b1));

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_oe);

  a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> !sda_oe);

  a_r9_no_commit_on_cond: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c || stop_c) |=> $stable(regs_o));
endmodule

bind i2c_cfg_slave i2c_cfg_slave_chk #(.W(NREG*8), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_r), .start_c(start_c), .stop_c(stop_c),
  .sda_oe(sda_oe), .regs_o(regs_o), .ptr(ptr)
);

// File: tb/sim_i2c_cfg_slave.sv
module sim_i2c_cfg_slave;
  localparam int Q = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe;
  logic [63:0] regs_o;
  wire  sda_bus = sda_m & ~sda_oe;

  i2c_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                    .addr_sel(addr_sel), .sda_oe(sda_oe), .regs_o(regs_o));

  always #5 clk = ~clk;

  int exp_q[$], act_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0, bad_moves = 0;
  logic oe_prev = 1'b0;

  task automatic chk(input string tag, input int e, input int a);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    act_q.push_back(a);
  endtask

  always @(negedge clk) begin
    while (act_q.size() > 0) begin
      int e, a;
      string t;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (e != a) begin
        n_bad++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", t, a, e);
      end
    end
  end

  always @(posedge clk) begin
    if (rst_n && sda_oe != oe_prev && scl_m) bad_moves++;
    oe_prev <= sda_oe;
  end

  function automatic int rg(input int i);
    return int'(regs_o[i*8 +: 8]);
  endfunction

  task automatic wq;
    repeat (Q) @(posedge clk);
    #2;
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack_n);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    read_bit(ack_n);
  endtask

  task automatic rbyte(output logic [7:0] d, input logic give_ack);
    for (int i = 7; i >= 0; i--) read_bit(d[i]);
    send_bit(~give_ack);
  endtask

  logic a;
  logic [7:0] rd;

  initial begin
    #200000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    wq();
    // R1 reset state
    for (int i = 0; i < 8; i++) chk($sformatf("R1 reg%0d", i), 0, rg(i));
    chk("R1 sda_oe", 0, int'(sda_oe));

    // R2 R4 R5 single write to reg 3
    bus_start();
    wbyte(8'hB0, a); chk("R2 addr ack", 0, int'(a));
    wbyte(8'h03, a); chk("R4 ptr ack", 0, int'(a));
    wbyte(8'hA5, a); chk("R5 data ack", 0, int'(a));
    chk("R5 reg3 before stop", 'hA5, rg(3));
    bus_stop();

    // R7 random read of reg 3
    bus_start();
    wbyte(8'hB0, a); wbyte(8'h03, a);
    bus_start();
    wbyte(8'hB1, a); chk("R7 read addr ack", 0, int'(a));
    rbyte(rd, 1'b0); chk("R7 read data", 'hA5, int'(rd));
    chk("R7 released after nack", 0, int'(sda_oe));
    bus_stop();

    // R4 high pointer bits ignored
    bus_start();
    wbyte(8'hB0, a); wbyte(8'h0E, a); wbyte(8'h3C, a);
    chk("R4 reg6 via 0x0E", 'h3C, rg(6));
    bus_stop();

    // R6 burst of nine from reg 6
    bus_start();
    wbyte(8'hB0, a); wbyte(8'h06, a);
    for (int k = 0; k < 9; k++) begin
      wbyte(8'h10 + 8'(k), a);
      chk($sformatf("R6 ack byte%0d", k), 0, int'(a));
      chk($sformatf("R6 reg%0d commit", (6 + k) % 8), 'h10 + k, rg((6 + k) % 8));
    end
    bus_stop();
    chk("R6 reg7 kept", 'h11, rg(7));
    chk("R6 reg6 overwritten", 'h18, rg(6));

    // R3 mismatch with addr_sel=0
    bus_start();
    wbyte(8'hB8, a); chk("R3 no ack", 1, int'(a));
    wbyte(8'h02, a); chk("R3 ptr ignored", 1, int'(a));
    wbyte(8'h77, a); chk("R3 data ignored", 1, int'(a));
    chk("R3 reg2 unchanged", 'h14, rg(2));
    bus_stop();

    // R2 with addr_sel=1
    addr_sel = 1'b1;
    wq();
    bus_start();
    wbyte(8'hB0, a); chk("R2 old addr rejected", 1, int'(a));
    bus_stop();
    bus_start();
    wbyte(8'hB8, a); chk("R2 sel addr ack", 0, int'(a));
    wbyte(8'h02, a); wbyte(8'h99, a);
    chk("R2 reg2 written", 'h99, rg(2));
    bus_stop();

    // R9 partial byte cut by STOP
    bus_start();
    wbyte(8'hB8, a); wbyte(8'h04, a); wbyte(8'h55, a);
    chk("R9 reg4 full byte", 'h55, rg(4));
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    bus_stop();
    chk("R9 reg5 untouched by stop", 'h17, rg(5));

    // R9 partial byte cut by repeated START, pointer kept
    bus_start();
    wbyte(8'hB8, a); wbyte(8'h01, a);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    bus_start();
    chk("R9 reg1 untouched by rstart", 'h13, rg(1));
    wbyte(8'hB9, a);
    rbyte(rd, 1'b0); chk("R9 pointer kept", 'h13, int'(rd));
    bus_stop();

    // R10 sequential read with wrap
    bus_start();
    wbyte(8'hB8, a); wbyte(8'h07, a);
    bus_start();
    wbyte(8'hB9, a);
    rbyte(rd, 1'b1); chk("R10 first", 'h11, int'(rd));
    rbyte(rd, 1'b0); chk("R10 wrapped", 'h12, int'(rd));
    bus_stop();

    // R8 drive changes only while SCL low
    chk("R8 oe moves with scl high", 0, bad_moves);

    repeat (10) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule